// File: doc/BRIEF.md
# Rotated Tiled View Address Generator

This block turns a pixel coordinate into an address inside a tiled view aperture. The caller gives a pixel format (8-bit, 16-bit, 32-bit or page), a three-bit orientation code and an X/Y coordinate. The block returns the aperture address, a valid flag and the line stride that goes with that format and orientation.

The address holds the orientation and format codes in its top five bits. Below them sits a linear offset. To build the offset, the block mirrors the coordinate along either axis, can swap the two axes, and scales the result by the bytes per pixel of the format. How many coordinate bits each axis uses depends on the format. A coordinate that does not fit gives an invalid, all-zero address. Mapping the aperture to physical memory is handled elsewhere.

A parameter selects one of two variants. In one, the outputs come straight from the inputs. In the other, all outputs pass through one register stage.

Top module: `tv_addr_gen`

## Requirements
- R1: Address bits [28:27] hold the format code: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit, 3 for page mode.
- R2: Address bits [31:29] repeat the orientation input. Orientation bit 0 is X-invert, bit 1 is Y-invert and bit 2 is XY-swap. Code 0 is 0°, 1 is 180° mirrored, 2 is 0° mirrored, 3 is 180°, 4 is 270° mirrored, 5 is 270°, 6 is 90° and 7 is 90° mirrored.
- R3: Each format drops some low bits from each axis. The (x, y) drops are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,5) for page mode. The X axis uses 14 minus its drop bits and the Y axis uses 13 minus its drop bits.
- R4: When X-invert is set, X is XORed with the all-ones mask of its usable width.
- R5: When Y-invert is set, Y is XORed with the all-ones mask of its usable width.
- R6: Without XY-swap, the offset is Y shifted left by the X width, plus X. With XY-swap, it is X shifted left by the Y width, plus Y.
- R7: The offset is shifted left by the sum of the two drop counts, so the low bits of the address are zero.
- R8: If X or Y is above its mask, or the input valid is low, the valid output is low and the address is 0.
- R9: The stride is 1 << (13 + x drop) when XY-swap is set, and 1 << (14 + y drop) otherwise. It is reported even when the coordinate is out of range.
- R10: With the register stage, every output follows its inputs by exactly one clock. Without it, the outputs follow in the same cycle.
- R11: With the register stage, reset forces valid, address and stride to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| fmt | input | 2 | Pixel format code |
| orient | input | 3 | Orientation code |
| x | input | 16 | Pixel column |
| y | input | 16 | Pixel row |
| out_vld | output | 1 | Address valid |
| addr | output | 32 | Aperture address |
| stride | output | 32 | Line stride in bytes |

## Verification
The bench builds the block twice with the default geometry of 14 width bits and 13 height bits: once with the register stage and once without. Both copies run on the same stimulus, so the one-cycle latency and the reset state of the registered copy can be checked against the same-cycle result of the other. The stimulus covers every format with every orientation. Coordinates sit on each mask, one above it and at random points, which reaches the out-of-range cases of all four formats.

// File: rtl/tv_pkg.sv
package tv_pkg;

    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } tv_fmt_e;

    typedef struct packed {
        logic swap;
        logic inv_y;
        logic inv_x;
    } tv_orient_t;

    typedef struct packed {
        logic [4:0] xs;   // dropped X bits
        logic [4:0] ys;   // dropped Y bits
        logic [4:0] xb;   // usable X bits
        logic [4:0] yb;   // usable Y bits
    } tv_geom_t;

    function automatic tv_geom_t tv_geometry(tv_fmt_e f, int wb, int hb, int sw, int sh);
        tv_geom_t g;
        int xs;
        int ys;
        case (f)
            FMT_B8:   begin xs = 0;  ys = 0;  end
            FMT_B16:  begin xs = 0;  ys = 1;  end
            FMT_B32:  begin xs = 1;  ys = 1;  end
            default:  begin xs = sw; ys = sh; end
        endcase
        g.xs = 5'(xs);
        g.ys = 5'(ys);
        g.xb = 5'(wb - xs);
        g.yb = 5'(hb - ys);
        return g;
    endfunction

endpackage

// File: rtl/tv_geom.sv
module tv_geom
    import tv_pkg::*;
#(
    parameter int W_BITS      = 14,
    parameter int H_BITS      = 13,
    parameter int SLOT_W_BITS = 6,
    parameter int SLOT_H_BITS = 5,
    parameter int ADDR_W      = W_BITS + H_BITS + 5
) (
    input  tv_fmt_e           fmt,
    input  tv_orient_t        orient,
    output tv_geom_t          geom,
    output logic [ADDR_W-1:0] stride
);
    always_comb begin
        geom = tv_geometry(fmt, W_BITS, H_BITS, SLOT_W_BITS, SLOT_H_BITS);
        if (orient.swap)
            stride = ADDR_W'(1) << (H_BITS + int'(geom.xs));
        else
            stride = ADDR_W'(1) << (W_BITS + int'(geom.ys));
    end
endmodule

// File: rtl/tv_offset.sv
module tv_offset
    import tv_pkg::*;
#(
    parameter int W_BITS  = 14,
    parameter int H_BITS  = 13,
    parameter int COORD_W = 16,
    parameter int OFF_W   = W_BITS + H_BITS
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  tv_geom_t           geom,
    input  tv_orient_t         orient,
    output logic               in_range,
    output logic [OFF_W-1:0]   offset
);
    logic [OFF_W-1:0] mask_x, mask_y, xw, yw, xm, ym, lin;

    always_comb begin
        mask_x   = (OFF_W'(1) << geom.xb) - OFF_W'(1);
        mask_y   = (OFF_W'(1) << geom.yb) - OFF_W'(1);
        xw       = OFF_W'(x);
        yw       = OFF_W'(y);
        in_range = (xw <= mask_x) && (yw <= mask_y);
        xm       = orient.inv_x ? (xw ^ mask_x) : xw;
        ym       = orient.inv_y ? (yw ^ mask_y) : yw;
        if (orient.swap)
            lin = (xm << geom.yb) + ym;
        else
            lin = (ym << geom.xb) + xm;
        offset = lin << (geom.xs + geom.ys);
    end
endmodule

// File: rtl/tv_addr_gen.sv
module tv_addr_gen
    import tv_pkg::*;
#(
    parameter int W_BITS      = 14,
    parameter int H_BITS      = 13,
    parameter int SLOT_W_BITS = 6,
    parameter int SLOT_H_BITS = 5,
    parameter int COORD_W     = 16,
    parameter bit REG_OUT     = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_vld,
    input  logic [1:0]                fmt,
    input  logic [2:0]                orient,
    input  logic [COORD_W-1:0]        x,
    input  logic [COORD_W-1:0]        y,
    output logic                      out_vld,
    output logic [W_BITS+H_BITS+4:0]  addr,
    output logic [W_BITS+H_BITS+4:0]  stride
);
    localparam int OFF_W  = W_BITS + H_BITS;
    localparam int ADDR_W = OFF_W + 5;
    localparam int PAGE_LOW = SLOT_W_BITS + SLOT_H_BITS;

    tv_geom_t          geom;
    tv_orient_t        ori;
    logic              in_range;
    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] stride_c, addr_c;
    logic              vld_c;

    assign ori = tv_orient_t'(orient);

    tv_geom #(
        .W_BITS(W_BITS), .H_BITS(H_BITS),
        .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS), .ADDR_W(ADDR_W)
    ) u_geom (
        .fmt(tv_fmt_e'(fmt)), .orient(ori), .geom(geom), .stride(stride_c)
    );

    tv_offset #(
        .W_BITS(W_BITS), .H_BITS(H_BITS), .COORD_W(COORD_W), .OFF_W(OFF_W)
    ) u_off (
        .x(x), .y(y), .geom(geom), .orient(ori), .in_range(in_range), .offset(offset)
    );

    always_comb begin
        vld_c  = in_vld && in_range;
        addr_c = vld_c ? {orient, fmt, offset} : '0;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_vld <= 1'b0;
                    addr    <= '0;
                    stride  <= '0;
                end else begin
                    out_vld <= vld_c;
                    addr    <= addr_c;
                    stride  <= stride_c;
                end
            end

            a_r1_fmt_field: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> addr[OFF_W+1:OFF_W] == $past(fmt));
            a_r2_orient_field: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> addr[ADDR_W-1:OFF_W+2] == $past(orient));
            a_r10_vld_follows: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> $past(in_vld));
        end else begin : g_comb
            assign out_vld = vld_c;
            assign addr    = addr_c;
            assign stride  = stride_c;

            a_r1_fmt_field: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> addr[OFF_W+1:OFF_W] == fmt);
            a_r2_orient_field: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> addr[ADDR_W-1:OFF_W+2] == orient);
            a_r10_vld_follows: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> in_vld);
        end
    endgenerate

    a_r8_zero_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> addr == '0);
    a_r9_stride_onehot: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $countones(stride) == 1);
    a_r7_page_low_zero: assert property (@(posedge clk) disable iff (rst)
        (out_vld && addr[OFF_W+1:OFF_W] == 2'd3) |-> addr[PAGE_LOW-1:0] == '0);

endmodule

// File: tb/sim_tv_addr_gen.sv
module sim_tv_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [2:0]  orient = 3'd0;
    logic [15:0] x = 16'd0;
    logic [15:0] y = 16'd0;
    logic        r_vld, c_vld;
    logic [31:0] r_addr, c_addr, r_str, c_str;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tv_addr_gen #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .fmt(fmt), .orient(orient),
        .x(x), .y(y), .out_vld(r_vld), .addr(r_addr), .stride(r_str));
    tv_addr_gen #(.REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .fmt(fmt), .orient(orient),
        .x(x), .y(y), .out_vld(c_vld), .addr(c_addr), .stride(c_str));

    // behavioural model: R1..R9
    task automatic model(input logic v, input int f, input int o, input int xi, input int yi,
                         output logic ev, output logic [31:0] ea, output logic [31:0] es);
        int xs, ys, xb, yb, mx, my, xx, yy;
        longint lin;
        xs = (f == 0) ? 0 : (f == 1) ? 0 : (f == 2) ? 1 : 6;
        ys = (f == 0) ? 0 : (f == 1) ? 1 : (f == 2) ? 1 : 5;
        xb = 14 - xs;
        yb = 13 - ys;
        mx = (1 << xb) - 1;
        my = (1 << yb) - 1;
        es = (o >= 4) ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
        ev = v && (xi <= mx) && (yi <= my);
        xx = (o % 2 == 1) ? (mx - xi) : xi;
        yy = ((o / 2) % 2 == 1) ? (my - yi) : yi;
        if (o >= 4) lin = longint'(xx) * (longint'(1) << yb) + yy;
        else        lin = longint'(yy) * (longint'(1) << xb) + xx;
        lin = lin * (longint'(1) << (xs + ys));
        ea = ev ? (32'(o) << 29) | (32'(f) << 27) | 32'(lin) : 32'd0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        pv;
    logic [31:0] pa, ps;
    bit          have_prev = 1'b0;

    task automatic apply(input logic v, input int f, input int o, input int xi, input int yi, input string tag);
        logic ev;
        logic [31:0] ea, es;
        @(posedge clk);
        #1;
        in_vld = v; fmt = 2'(f); orient = 3'(o); x = 16'(xi); y = 16'(yi);
        model(v, f, o, xi, yi, ev, ea, es);
        @(negedge clk);
        chk({tag, " comb vld R8"}, {31'd0, c_vld}, {31'd0, ev});
        chk({tag, " comb addr R1 R2 R3 R4 R5 R6 R7"}, c_addr, ea);
        chk({tag, " comb stride R9"}, c_str, es);
        if (have_prev) begin
            chk({tag, " reg vld R10"}, {31'd0, r_vld}, {31'd0, pv});
            chk({tag, " reg addr R10"}, r_addr, pa);
            chk({tag, " reg stride R10"}, r_str, ps);
        end
        pv = ev; pa = ea; ps = es; have_prev = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("reset vld R11", {31'd0, r_vld}, 32'd0);
        chk("reset addr R11", r_addr, 32'd0);
        chk("reset stride R11", r_str, 32'd0);
        rst = 1'b0;
        // R1 R2 simple identity points
        apply(1, 0, 0, 1, 0, "origin8");
        apply(1, 0, 0, 0, 1, "row8");
        apply(0, 1, 3, 5, 5, "novld");
        // every format and orientation at corners, mask, mask+1
        for (int f = 0; f < 4; f++) begin
            for (int o = 0; o < 8; o++) begin
                int mx, my;
                mx = (f == 3) ? 255 : (f == 2) ? 8191 : 16383;
                my = (f == 3) ? 255 : (f == 0) ? 8191 : 4095;
                apply(1, f, o, 0, 0, "zero R4 R5");
                apply(1, f, o, mx, my, "mask R3");
                apply(1, f, o, mx + 1, 0, "xover R8");
                apply(1, f, o, 0, my + 1, "yover R8");
                apply(1, f, o, 3, 7, "small R6 R7");
            end
        end
        for (int i = 0; i < 400; i++) begin
            apply(1'($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                  int'($urandom_range(0, 17000)), int'($urandom_range(0, 9000)), "rand");
        end
        apply(0, 0, 0, 0, 0, "drain");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule